// File: doc/BRIEF.md
# Shared-Address Segment Packer

This block lays data segments into the local memory maps of a set of processor groups, one segment per request, in the order the requests arrive. A request names a submachine with a ternary pattern over the group index (each index bit is fixed to 0, fixed to 1, or left free) and gives a segment length counted in fixed-size memory blocks. All member groups of a submachine must see the segment at one common start address. The block picks the lowest such address that lands on no earlier segment in any member, and then raises the occupancy of every member.

Each group keeps only the address just above its highest occupied block. The shared start is the largest of these tops across the members. Any member whose top lies below that start is left with an unused gap under the new segment. The block flags that gap, adds its size to a running gap total, and reports the tallest memory map seen so far. Requests and results move over valid/ready handshakes. Only one request is in flight at a time, because each placement depends on the tops written by the one before it. A synchronous clear empties every map.

Top module: `seg_packer`

## Requirements
- R1: Group g belongs to a request's submachine when, for every index bit b with `req_care[b]`=1, bit b of g equals `req_value[b]`; a bit with `req_care[b]`=0 matches both values.
- R2: `res_start` equals the largest top-of-occupancy among the member groups, which is the lowest address shared by all members that overwrites no placed block (0 for empty maps).
- R3: After a placement of nonzero length L, every member's top becomes `res_start`+L and every non-member's top is unchanged, as later starts show.
- R4: A zero-length request changes no top, leaves `res_hole` at 0 and leaves `hole_blocks` unchanged; `res_start` still reports the address it would have used.
- R5: `res_hole` is 1 exactly when the length is nonzero and at least one member's top is below `res_start`.
- R6: `hole_blocks` accumulates, for each nonzero-length placement, the sum over members of (`res_start` minus that member's previous top), modulo 2^HOLE_W.
- R7: With each result, `res_peak` equals the largest top across all groups; it never falls except on clear.
- R8: A request is taken on a rising edge with `req_valid` and `req_ready` both high. `res_valid` is low in the cycle after that edge and high after the next edge. The result holds steady until a rising edge with `res_ready` high. `req_ready` is low while a request is in flight or a result waits unconsumed.
- R9: `clear` is synchronous. It zeroes every top, `res_peak` and `hole_blocks`, discards any request in flight and any pending result, and holds `req_ready` low while asserted.
- R10: After reset, `res_valid`=0, `req_ready`=1, `res_peak`=0, `hole_blocks`=0 and all tops are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous empty of all maps and counters |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_care | input | GB | Ternary pattern: 1 = index bit fixed, 0 = free |
| req_value | input | GB | Value of each fixed index bit |
| req_len | input | LEN_W | Segment length in blocks |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes the result |
| res_start | output | PTR_W | Shared start address in blocks |
| res_hole | output | 1 | Placement left a gap below the segment |
| res_peak | output | PTR_W | Tallest map size so far in blocks |
| hole_blocks | output | HOLE_W | Running total of gap blocks |

## Verification
The bench builds the block with its default values: 4 index bits (16 groups), 12-bit addresses and 6-bit lengths. With 16 groups, all 81 ternary patterns can be issued in full sweeps. These cover single groups, the whole machine and every overlapping shape in between, with mixed lengths including zero. Since nested and non-nested patterns are interleaved, gaps arise often, and the gap total and peak are tracked against an arithmetic model in the bench. Held results and clears issued mid-flight exercise the handshake and discard rules.

// File: rtl/segpack_pkg.sv
package segpack_pkg;
  // Default geometry: 2**GB groups, map addresses and lengths in blocks.
  localparam int GB_DEF     = 4;
  localparam int PTR_W_DEF  = 12;
  localparam int LEN_W_DEF  = 6;
  localparam int HOLE_W_DEF = 16;
endpackage

// File: rtl/segpack_decode.sv
// Turns a ternary pattern into a one-bit-per-group membership vector (R1).
module segpack_decode #(
  parameter int GB = 4,
  localparam int N = 1 << GB
) (
  input  logic [GB-1:0] care,
  input  logic [GB-1:0] value,
  output logic [N-1:0]  member
);
  for (genvar g = 0; g < N; g++) begin : g_grp
    assign member[g] = (((GB'(g)) ^ value) & care) == '0;
  end
endmodule

// File: rtl/segpack_tree.sv
// Balanced reduction over 2**LB selected leaves; ADD picks sum or maximum.
module segpack_tree #(
  parameter int LB  = 4,
  parameter int W   = 12,
  parameter bit ADD = 1'b0,
  localparam int N  = 1 << LB
) (
  input  logic [N-1:0]        sel,
  input  logic [N-1:0][W-1:0] leaf,
  output logic [W-1:0]        root
);
  for (genvar l = 0; l <= LB; l++) begin : lv
    localparam int CNT = N >> l;
    logic [W-1:0] v [CNT];
    if (l == 0) begin : g_leaf
      for (genvar i = 0; i < CNT; i++) begin : g_i
        assign v[i] = sel[i] ? leaf[i] : '0;
      end
    end else if (ADD) begin : g_sum
      for (genvar i = 0; i < CNT; i++) begin : g_i
        assign v[i] = lv[l-1].v[2*i] + lv[l-1].v[2*i+1];
      end
    end else begin : g_max
      for (genvar i = 0; i < CNT; i++) begin : g_i
        assign v[i] = (lv[l-1].v[2*i] > lv[l-1].v[2*i+1]) ?
                      lv[l-1].v[2*i] : lv[l-1].v[2*i+1];
      end
    end
  end
  assign root = lv[LB].v[0];
endmodule

// File: rtl/segpack_ptrs.sv
// Per-group top-of-occupancy registers.
module segpack_ptrs #(
  parameter int GB    = 4,
  parameter int PTR_W = 12,
  localparam int N    = 1 << GB
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    grow,
  input  logic [N-1:0]            member,
  input  logic [PTR_W-1:0]        new_top,
  output logic [N-1:0][PTR_W-1:0] ptrs
);
  for (genvar g = 0; g < N; g++) begin : g_grp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ptrs[g] <= '0;
      end else if (clear) begin
        ptrs[g] <= '0;
      end else if (grow && member[g]) begin
        ptrs[g] <= new_top;
      end
    end
  end
endmodule

// File: rtl/seg_packer.sv
module seg_packer
  import segpack_pkg::*;
#(
  parameter int GB     = GB_DEF,
  parameter int PTR_W  = PTR_W_DEF,
  parameter int LEN_W  = LEN_W_DEF,
  parameter int HOLE_W = HOLE_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [GB-1:0]     req_care,
  input  logic [GB-1:0]     req_value,
  input  logic [LEN_W-1:0]  req_len,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [PTR_W-1:0]  res_start,
  output logic              res_hole,
  output logic [PTR_W-1:0]  res_peak,
  output logic [HOLE_W-1:0] hole_blocks
);
  localparam int N = 1 << GB;

  logic                    s1_valid;
  logic [N-1:0]            s1_member;
  logic [LEN_W-1:0]        s1_len;
  logic [N-1:0]            dec_member;
  logic [N-1:0][PTR_W-1:0] ptrs;
  logic [N-1:0][HOLE_W-1:0] gap_leaf;
  logic [PTR_W-1:0]        start_c;
  logic [PTR_W-1:0]        top_c;
  logic [HOLE_W-1:0]       gap_c;
  logic                    accept;
  logic                    grow;

  segpack_decode #(.GB(GB)) u_dec (
    .care   (req_care),
    .value  (req_value),
    .member (dec_member)
  );

  // One request in flight: the next start depends on this one's tops.
  assign req_ready = !clear && !s1_valid && (!res_valid || res_ready);
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid  <= 1'b0;
      s1_member <= '0;
      s1_len    <= '0;
    end else if (clear) begin
      s1_valid  <= 1'b0;
    end else begin
      s1_valid <= accept;
      if (accept) begin
        s1_member <= dec_member;
        s1_len    <= req_len;
      end
    end
  end

  segpack_tree #(.LB(GB), .W(PTR_W), .ADD(1'b0)) u_max (
    .sel  (s1_member),
    .leaf (ptrs),
    .root (start_c)
  );

  for (genvar g = 0; g < N; g++) begin : g_gap
    assign gap_leaf[g] = HOLE_W'(start_c - ptrs[g]);
  end

  segpack_tree #(.LB(GB), .W(HOLE_W), .ADD(1'b1)) u_gap (
    .sel  (s1_member),
    .leaf (gap_leaf),
    .root (gap_c)
  );

  assign top_c = start_c + PTR_W'(s1_len);
  assign grow  = s1_valid && !clear && (s1_len != '0);

  segpack_ptrs #(.GB(GB), .PTR_W(PTR_W)) u_ptrs (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (clear),
    .grow    (grow),
    .member  (s1_member),
    .new_top (top_c),
    .ptrs    (ptrs)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      res_start   <= '0;
      res_hole    <= 1'b0;
      res_peak    <= '0;
      hole_blocks <= '0;
    end else if (clear) begin
      res_valid   <= 1'b0;
      res_hole    <= 1'b0;
      res_peak    <= '0;
      hole_blocks <= '0;
    end else begin
      if (s1_valid) begin
        res_valid <= 1'b1;
        res_start <= start_c;
        res_hole  <= grow && (gap_c != '0);
      end else if (res_ready) begin
        res_valid <= 1'b0;
      end
      if (grow) begin
        hole_blocks <= hole_blocks + gap_c;
        if (top_c > res_peak) res_peak <= top_c;
      end
    end
  end
endmodule

// File: rtl/segpack_chk.sv
module segpack_chk #(
  parameter int PTR_W  = 12,
  parameter int HOLE_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clear,
  input logic              req_valid,
  input logic              req_ready,
  input logic              res_valid,
  input logic              res_ready,
  input logic [PTR_W-1:0]  res_start,
  input logic              res_hole,
  input logic [PTR_W-1:0]  res_peak,
  input logic [HOLE_W-1:0] hole_blocks
);
  a_r8_result_held: assert property (@(posedge clk) disable iff (!rst_n || clear)
    res_valid && !res_ready |=> res_valid && $stable(res_start) && $stable(res_hole));

  a_r8_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |-> !req_ready);

  a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n || clear)
    req_valid && req_ready |=> !res_valid ##1 res_valid);

  a_r7_peak_covers_start: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_peak >= res_start);

  a_r7_peak_rises: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> res_peak >= $past(res_peak));

  a_r9_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> res_peak == '0 && hole_blocks == '0 && !res_valid);

  a_r9_clear_no_ready: assert property (@(posedge clk) disable iff (!rst_n)
    clear |-> !req_ready);

  a_r6_total_moves_on_hole: assert property (@(posedge clk) disable iff (!rst_n)
    !clear ##1 (hole_blocks != $past(hole_blocks)) |-> res_valid && res_hole);

  a_r5_hole_needs_height: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_hole |-> res_start != '0);
endmodule

bind seg_packer segpack_chk #(.PTR_W(PTR_W), .HOLE_W(HOLE_W)) u_chk (.*);

// File: tb/sim_seg_packer.sv
module sim_seg_packer;
  localparam int GB = 4, N = 16, PW = 12, LW = 6, HW = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, clear = 1'b0, req_valid = 1'b0, res_ready = 1'b1;
  logic [GB-1:0] req_care = '0, req_value = '0;
  logic [LW-1:0] req_len = '0;
  logic req_ready, res_valid, res_hole;
  logic [PW-1:0] res_start, res_peak;
  logic [HW-1:0] hole_blocks;

  seg_packer #(.GB(GB), .PTR_W(PW), .LEN_W(LW), .HOLE_W(HW)) u0 (
    .clk(clk), .rst_n(rst_n), .clear(clear), .req_valid(req_valid),
    .req_ready(req_ready), .req_care(req_care), .req_value(req_value),
    .req_len(req_len), .res_valid(res_valid), .res_ready(res_ready),
    .res_start(res_start), .res_hole(res_hole), .res_peak(res_peak),
    .hole_blocks(hole_blocks));

  int errors = 0, checks = 0;
  int mptr[N];
  int mpeak = 0, mholes = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int g = 0; g < N; g++) mptr[g] = 0;
    mpeak = 0;
    mholes = 0;
  endtask

  task automatic place(input int c, input int v, input int len, input int hold);
    int st, gap, hole;
    st = 0; gap = 0;
    for (int g = 0; g < N; g++)
      if (((g ^ v) & c) == 0 && mptr[g] > st) st = mptr[g];
    for (int g = 0; g < N; g++)
      if (((g ^ v) & c) == 0) gap += st - mptr[g];
    hole = (len > 0 && gap > 0) ? 1 : 0;
    if (len > 0) begin
      for (int g = 0; g < N; g++)
        if (((g ^ v) & c) == 0) mptr[g] = st + len;
      mholes = (mholes + gap) % (1 << HW);
      for (int g = 0; g < N; g++) if (mptr[g] > mpeak) mpeak = mptr[g];
    end
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    res_ready = (hold == 0);
    req_valid = 1'b1;
    req_care  = GB'(c);
    req_value = GB'(v);
    req_len   = LW'(len);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8 no result one cycle after accept", int'(res_valid), 0);
    chk("R8 ready low while in flight", int'(req_ready), 0);
    @(negedge clk);
    chk("R8 result valid", int'(res_valid), 1);
    chk("R1 R2 R3 shared start", int'(res_start), st);
    chk(len == 0 ? "R4 zero-length hole flag" : "R5 hole flag", int'(res_hole), hole);
    chk(len == 0 ? "R4 zero-length hole total" : "R6 hole total", int'(hole_blocks), mholes);
    chk("R7 peak", int'(res_peak), mpeak);
    if (hold > 0) begin
      for (int k = 0; k < hold; k++) begin
        @(negedge clk);
        chk("R8 result held", int'(res_valid), 1);
        chk("R8 start held", int'(res_start), st);
        chk("R8 ready low while result pending", int'(req_ready), 0);
      end
      res_ready = 1'b1;
      @(negedge clk);
      chk("R8 result taken", int'(res_valid), 0);
    end
  endtask

  task automatic do_clear();
    @(negedge clk);
    clear = 1'b1;
    #1 chk("R9 ready low during clear", int'(req_ready), 0);
    @(negedge clk);
    clear = 1'b0;
    model_clear();
    chk("R9 peak cleared", int'(res_peak), 0);
    chk("R9 hole total cleared", int'(hole_blocks), 0);
    chk("R9 no result after clear", int'(res_valid), 0);
  endtask

  function automatic int pat_care(input int m);
    int c = 0, t = m;
    for (int b = 0; b < GB; b++) begin
      if (t % 3 != 0) c |= (1 << b);
      t /= 3;
    end
    return c;
  endfunction

  function automatic int pat_value(input int m);
    int v = 0, t = m;
    for (int b = 0; b < GB; b++) begin
      if (t % 3 == 2) v |= (1 << b);
      t /= 3;
    end
    return v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R8 watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset res_valid", int'(res_valid), 0);
    chk("R10 reset req_ready", int'(req_ready), 1);
    chk("R10 reset peak", int'(res_peak), 0);
    chk("R10 reset hole total", int'(hole_blocks), 0);

    // Sweep 1: every ternary pattern, mixed lengths, some held results.
    for (int m = 0; m < 81; m++)
      place(pat_care(m), pat_value(m), (m * 5 + 3) % 7, (m % 17 == 5) ? 2 : 0);

    // Clear while a request is in flight: it must be discarded (R9).
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_care = '0; req_value = '0; req_len = LW'(5);
    @(negedge clk);
    req_valid = 1'b0;
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    model_clear();
    chk("R9 in-flight request discarded", int'(res_valid), 0);
    @(negedge clk);
    chk("R9 in-flight request stays discarded", int'(res_valid), 0);
    chk("R9 peak after mid-flight clear", int'(res_peak), 0);

    // Sweep 2: reverse order, short lengths.
    for (int m = 80; m >= 0; m--)
      place(pat_care(m), pat_value(m), (m * 3) % 4, 0);

    do_clear();

    // Sweep 3: scattered patterns, longer lengths.
    for (int k = 0; k < 41; k++)
      place(pat_care((k * 37) % 81), pat_value((k * 37) % 81), k % 9, (k % 13 == 4) ? 3 : 0);

    // Zero-length on an empty-map group after clear: start 0, nothing moves (R4).
    do_clear();
    place(1, 0, 0, 0);
    place(0, 0, 7, 0);
    place(15, 3, 0, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule